// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a binary-search analog-to-digital conversion. It drives an N-bit trial code into an external DAC. Each cycle it reads one comparator bit, which is high when the analog input lies at or above the DAC output. When the search is complete it publishes the resulting code. A one-cycle start pulse launches a conversion. The controller spends one clock clearing its trial register and one clock seeding the mid-scale code. It then takes one decision per bit, from the most significant bit down. The result therefore lands a fixed N+1 clock periods after the start edge, whatever the input level.

Surrounding logic watches `busy` to know when the analog front end must hold still. A one-cycle `done` pulse marks a fresh code in `result`. `result` keeps that code until the next conversion completes, so it can be read at any later time. Start requests that arrive during a conversion are dropped.

Top module: `sar_conv_ctrl`

## Requirements
- R1: With the controller idle and `startReq` high at a rising edge, `dacCode` reads all zeros and `busy` reads 1 in the cycle that follows. `busy` never rises without such a start.
- R2: In the cycle after the cleared cycle, `dacCode` has only bit WIDTH-1 set. This is the mid-scale code.
- R3: At each decision edge the bit under test takes the value of `cmpAbove`: 1 keeps it set, 0 clears it. If that bit is not bit 0, the next lower bit is set to 1 for the next trial.
- R4: Between consecutive busy cycles, at most one bit of `dacCode` goes from 1 to 0. Bits above the bit under test never change once they are decided.
- R5: `done` rises exactly WIDTH+1 clock edges after the start edge and lasts one cycle. `busy` is high for exactly WIDTH+1 cycles and is low while `done` is high.
- R6: The code in `result` consists of every decided bit. With a comparator that reports 1 when a target code is greater than or equal to `dacCode`, `result` equals that target.
- R7: A `startReq` while `busy` is high is ignored. The running conversion keeps its trial code and finishes on its original schedule with its original result.
- R8: `result` changes only on the edge that raises `done`. Between conversions, and while a new conversion runs, it holds the last completed code.
- R9: After reset, `busy`, `done`, `dacCode` and `result` are all zero.
- R10: The width is a parameter (default 8). The same behaviour holds for widths 8 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start pulse, taken only when idle |
| cmpAbove | input | 1 | Comparator: analog input at or above DAC output |
| dacCode | output | WIDTH | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a result is written |
| result | output | WIDTH | Last completed conversion code |

## Verification
Several properties are checked on every cycle. These are the cleared and mid-scale codes that open a conversion, the rule that at most one bit is dropped per decision, and the single-cycle `done` pulse. The checks also cover the WIDTH+1 busy length, measured with a counter, `result` holding between completions, and the fact that a running conversion is never cleared by a second start. Whether each bit decision follows the comparator, and whether the final code equals the analog level, can only be shown by the bench scenarios. These model the comparator against a target code. They sweep every 12-bit target and every 8-bit target side by side, with start pulses injected mid-conversion and back-to-back starts on the `done` cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CLEAR  = 2'd1,
    ST_DECIDE = 2'd2
  } sar_state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearTrial;
    logic seedMsb;
    logic decide;
    logic finish;
  } sar_strobe_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PTR_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  output sar_strobe_t      strobe,
  output logic [PTR_W-1:0] bitSel,
  output logic             busy,
  output logic             done
);

  localparam logic [PTR_W-1:0] TOP_BIT = PTR_W'(WIDTH - 1);

  sar_state_e state, stateNext;
  logic [PTR_W-1:0] ptrQ, ptrNext;
  logic doneQ;

  always_comb begin
    stateNext  = state;
    ptrNext    = ptrQ;
    strobe     = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.clearTrial = 1'b1;
          stateNext         = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        strobe.seedMsb = 1'b1;
        ptrNext        = TOP_BIT;
        stateNext      = ST_DECIDE;
      end
      ST_DECIDE: begin
        strobe.decide = 1'b1;
        if (ptrQ == '0) begin
          strobe.finish = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          ptrNext = ptrQ - PTR_W'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ptrQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      ptrQ  <= ptrNext;
      doneQ <= strobe.finish;
    end
  end

  assign bitSel = ptrQ;
  assign busy   = (state != ST_IDLE);
  assign done   = doneQ;

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PTR_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  sar_strobe_t      strobe,
  input  logic [PTR_W-1:0] bitSel,
  input  logic             cmpAbove,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] result
);

  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trialQ, resultQ, decided;

  // per-bit decision: bit under test follows comparator, next lower bit gets set
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic underTest;
    assign underTest = strobe.decide && (bitSel == PTR_W'(i));
    if (i < WIDTH - 1) begin : g_hasUpper
      logic upperTest;
      assign upperTest  = strobe.decide && (bitSel == PTR_W'(i + 1));
      assign decided[i] = underTest ? cmpAbove : (upperTest ? 1'b1 : trialQ[i]);
    end else begin : g_top
      assign decided[i] = underTest ? cmpAbove : trialQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialQ  <= '0;
      resultQ <= '0;
    end else begin
      if (strobe.clearTrial)   trialQ <= '0;
      else if (strobe.seedMsb) trialQ <= MID_CODE;
      else if (strobe.decide)  trialQ <= decided;
      if (strobe.finish) resultQ <= decided;
    end
  end

  assign trial  = trialQ;
  assign result = resultQ;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             cmpAbove,
  output logic [WIDTH-1:0] dacCode,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  localparam int PTR_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  sar_strobe_t      strobe;
  logic [PTR_W-1:0] bitSel;

  sar_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strobe   (strobe),
    .bitSel   (bitSel),
    .busy     (busy),
    .done     (done)
  );

  sar_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bitSel   (bitSel),
    .cmpAbove (cmpAbove),
    .trial    (dacCode),
    .result   (result)
  );

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [WIDTH-1:0] dacCode,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);

  localparam int CNT_W = $clog2(WIDTH + 3) + 1;
  localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CNT_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + CNT_W'(1);
    else           busyCnt <= '0;
  end

  // R1
  clear_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> dacCode == '0);

  // R1
  start_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !startReq |=> !busy);

  // R2
  mid_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> dacCode == MID_CODE);

  // R4
  one_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) && busy |-> $onehot0($past(dacCode) & ~dacCode));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busyCnt == CNT_W'(WIDTH + 1));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) && busy |-> dacCode != '0 || $past(dacCode) == '0 || $past(dacCode) == MID_CODE);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .dacCode  (dacCode),
  .busy     (busy),
  .done     (done),
  .result   (result)
);

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [7:0]  tgt8 = '0;
  logic [11:0] tgt12 = '0;
  logic [7:0]  dac8, res8;
  logic [11:0] dac12, res12;
  logic busy8, done8, busy12, done12;
  logic cmp8, cmp12;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // comparator model: input at or above DAC level
  assign cmp8  = (tgt8 >= dac8);
  assign cmp12 = (tgt12 >= dac12);

  sar_conv_ctrl #(.WIDTH(8)) u_sar_conv_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpAbove(cmp8),
    .dacCode(dac8), .busy(busy8), .done(done8), .result(res8));

  sar_conv_ctrl #(.WIDTH(12)) u_sar_conv_ctrl12 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpAbove(cmp12),
    .dacCode(dac12), .busy(busy12), .done(done12), .result(res12));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // trial expected after edge c (c >= 2) of a conversion of width n
  function automatic int expTrial(input int t, input int n, input int c);
    int p = n - c + 1;
    int v = (t >> p) << p;
    if (p > 0) v = v | (1 << (p - 1));
    return v;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // one conversion on both widths; caller is at a negedge
  task automatic runConv(input int t12, input int t8, input bit restart,
                         inout int prev8, inout int prev12);
    tgt8 = t8[7:0];
    tgt12 = t12[11:0];
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(dac8 == 8'h00 && busy8, "R1 clear w8", int'(dac8), 0);
    chk(dac12 == 12'h000 && busy12, "R1 clear w12", int'(dac12), 0);
    for (int c = 1; c <= 13; c++) begin
      startReq = restart && (c == 3);
      @(negedge clk);
      startReq = 1'b0;
      if (c == 1) begin
        chk(dac8 == 8'h80, "R2 mid w8", int'(dac8), 'h80);
        chk(dac12 == 12'h800, "R2 mid w12", int'(dac12), 'h800);
      end else begin
        if (c <= 9)
          chk(int'(dac8) == expTrial(t8, 8, c), restart ? "R7 trial w8" : "R3 trial w8",
              int'(dac8), expTrial(t8, 8, c));
        chk(int'(dac12) == expTrial(t12, 12, c), restart ? "R7 trial w12" : "R3 trial w12",
            int'(dac12), expTrial(t12, 12, c));
      end
      if (c < 9) begin
        chk(busy8 && !done8, "R5 busy w8", int'({busy8, done8}), 2);
        chk(int'(res8) == prev8, "R8 hold w8", int'(res8), prev8);
      end else if (c == 9) begin
        chk(!busy8 && done8, "R5 done w8", int'({busy8, done8}), 1);
        chk(int'(res8) == t8, "R6 result w8", int'(res8), t8);
        prev8 = t8;
      end else begin
        chk(!done8 && int'(res8) == prev8, "R8 after w8", int'(res8), prev8);
      end
      if (c < 13) begin
        chk(busy12 && !done12, "R5 busy w12", int'({busy12, done12}), 2);
        chk(int'(res12) == prev12, "R8 hold w12", int'(res12), prev12);
      end else begin
        chk(!busy12 && done12, "R5 done w12", int'({busy12, done12}), 1);
        chk(int'(res12) == t12, "R6 R10 result w12", int'(res12), t12);
        prev12 = t12;
      end
    end
  endtask

  initial begin
    int prev8 = 0;
    int prev12 = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy8 && !done8 && dac8 == 0 && res8 == 0, "R9 reset w8", int'(res8), 0);
    chk(!busy12 && !done12 && dac12 == 0 && res12 == 0, "R9 reset w12", int'(res12), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy8 && !busy12, "R1 no start no busy", int'({busy8, busy12}), 0);
    // R10 sweep: every 12-bit code, every 8-bit code, back-to-back starts
    for (int k = 0; k < 4096; k++) begin
      runConv(k, (k * 37 + 11) % 256, (k % 97) == 5, prev8, prev12);
    end
    // R8: idle hold with moved targets
    tgt8 = 8'h5A;
    tgt12 = 12'hA5A;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(int'(res8) == prev8 && !done8 && !busy8, "R8 idle w8", int'(res8), prev8);
      chk(int'(res12) == prev12 && !done12 && !busy12, "R8 idle w12", int'(res12), prev12);
    end
    // extremes with a restart request inside the run (R7)
    runConv(12'hFFF, 8'hFF, 1'b1, prev8, prev12);
    runConv(0, 0, 1'b1, prev8, prev12);
    @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 1, 0);
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule